// File: doc/BRIEF.md
# Interrupt Source State Controller

This block holds the delivery state of a parameterized set of interrupt sources and decides when each one must be presented to the downstream presentation logic. Every source is either level-signalled (its input line is a wire that stays high while the condition lasts) or message-signalled (each cycle its input line is high counts as one event). Each source carries a destination server, a current priority, a remembered priority and four status flags. A priority of all ones masks the source.

Software-side agents drive a configuration port: set destination and priority, read back, disable, enable and change the signalling type. The presentation logic feeds back three events: a reject of a delivered source, a request to rescan all sources for re-delivery, and an end-of-interrupt. Deliveries leave the block one at a time through a valid/ready handshake that carries the server, the global source number and the priority. The lowest-indexed source with a request is offered first.

Top module: `irq_source_ctl`

## Requirements
- R1: Global source numbers are the local index plus 16. A number is accepted only when it lies in 16 to 16+NUM_SRC-1. A configuration request naming any other number answers with cfg_err=1 and changes nothing. Rejects and end-of-interrupt events naming such a number are ignored.
- R2: A read (cfg_op=1) returns on rd_status the flags of the named source: bit 0 line asserted, bit 1 sent, bit 2 rejected, bit 3 masked-pending. It also returns the server, the priority and the type (rd_lvl=1 for level).
- R3: A message source triggered while its priority is 8'hFF sets masked-pending and is not offered. Triggered while unmasked, it is offered on dlv_* from the next cycle. If a queued message request sees its source become masked before it is accepted, the request turns into masked-pending.
- R4: dlv_valid presents server, global number and priority of the lowest-indexed requesting source. The offer stays until dlv_ready is high at a clock edge, and an accepted message request is then removed.
- R5: A level source copies its line into the asserted flag each cycle. It is offered only while it is unmasked, asserted and not sent. Acceptance sets sent, so a line that is still high is not offered again.
- R6: A reject sets the rejected flag and clears the sent flag of the named source. When a reject meets an acceptance of the same level source in one cycle, the sent flag ends cleared.
- R7: During a resend scan, a message source found with the rejected flag has the flag cleared and is offered again if unmasked.
- R8: An end-of-interrupt clears the sent flag of a level source, which is then offered again if its line is still high. It leaves a message source's flags unchanged.
- R9: A set (cfg_op=0) writes server, priority and remembered priority. A masked-pending message source that becomes unmasked by any configuration write clears masked-pending and is offered. A level source re-applies the rule of R5 with its new priority.
- R10: Disable (cfg_op=2) stores the current priority as the remembered priority and writes 8'hFF. Enable (cfg_op=3) writes the remembered priority back.
- R11: Each configuration request is answered by cfg_ack one cycle later. cfg_err is 1 for a bad number, an unknown opcode (5 to 7), or a set whose server is NUM_SRV or above.
- R12: A resend scan (rsd_start) visits one source per cycle, NUM_SRC cycles in all, with rsd_busy high throughout. It does not advance while an offer waits for acceptance.
- R13: soft_rst sets every source to server 0, status 0, and priority and remembered priority 8'hFF, but keeps each source's type (cfg_op=4 writes the type from cfg_lvl). rst_n resets everything, including the types, which take the value LVL_INIT.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous state clear that keeps types |
| src_line | input | NUM_SRC | Per-source interrupt lines |
| cfg_valid | input | 1 | Configuration request strobe |
| cfg_op | input | 3 | 0 set, 1 read, 2 disable, 3 enable, 4 type |
| cfg_num | input | NUM_W | Global source number |
| cfg_server | input | SRV_W | Server for set |
| cfg_prio | input | PRIO_W | Priority for set |
| cfg_lvl | input | 1 | Type for type write (1 = level) |
| cfg_ack | output | 1 | Request answered |
| cfg_err | output | 1 | Request refused |
| rd_server | output | SRV_W | Read-back server |
| rd_prio | output | PRIO_W | Read-back priority |
| rd_status | output | 4 | Read-back status flags |
| rd_lvl | output | 1 | Read-back type |
| rej_valid | input | 1 | Reject event |
| rej_num | input | NUM_W | Rejected global number |
| eoi_valid | input | 1 | End-of-interrupt event |
| eoi_num | input | NUM_W | Global number for end-of-interrupt |
| rsd_start | input | 1 | Start a resend scan |
| rsd_busy | output | 1 | Resend scan in progress |
| dlv_valid | output | 1 | Delivery offered |
| dlv_ready | input | 1 | Delivery accepted |
| dlv_server | output | SRV_W | Destination server |
| dlv_num | output | NUM_W | Global source number |
| dlv_prio | output | PRIO_W | Delivery priority |

## Verification
The acceptance of a level source and a reject of the same source can arrive in one cycle. One pushes the sent flag up and the other pulls it down. The bench raises dlv_ready and rej_valid together while the line stays high. It judges the result by the offer reappearing in the next cycle and by the read-back flags showing asserted and rejected with sent clear. A lone acceptance is used as the contrast, after which the offer must vanish.

// File: rtl/irqsrc_pkg.sv
package irqsrc_pkg;
  localparam int ST_W        = 4;
  localparam int ST_ASSERTED = 0;
  localparam int ST_SENT     = 1;
  localparam int ST_REJECTED = 2;
  localparam int ST_MASKPEND = 3;

  localparam logic [2:0] OP_SET  = 3'd0;
  localparam logic [2:0] OP_GET  = 3'd1;
  localparam logic [2:0] OP_OFF  = 3'd2;
  localparam logic [2:0] OP_ON   = 3'd3;
  localparam logic [2:0] OP_TYPE = 3'd4;
endpackage

// File: rtl/irqsrc_slot.sv
module irqsrc_slot
  import irqsrc_pkg::*;
#(
  parameter int   SRV_W    = 4,
  parameter int   PRIO_W   = 8,
  parameter logic LVL_INIT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_clr,
  input  logic              line,
  input  logic              wr_en,
  input  logic [SRV_W-1:0]  wr_server,
  input  logic [PRIO_W-1:0] wr_prio,
  input  logic [PRIO_W-1:0] wr_saved,
  input  logic              type_en,
  input  logic              type_lvl,
  input  logic              accept,
  input  logic              reject,
  input  logic              eoi,
  input  logic              scan_hit,
  output logic              req,
  output logic [SRV_W-1:0]  server,
  output logic [PRIO_W-1:0] prio,
  output logic [PRIO_W-1:0] saved,
  output logic [ST_W-1:0]   status,
  output logic              lvl
);
  localparam logic [PRIO_W-1:0] MASKED = '1;

  logic [SRV_W-1:0]  server_q, server_d;
  logic [PRIO_W-1:0] prio_q, prio_d, saved_q, saved_d;
  logic [ST_W-1:0]   st_q, st_d;
  logic              pend_q, pend_d, lvl_q, lvl_d;

  always_comb begin
    server_d = server_q;
    prio_d   = prio_q;
    saved_d  = saved_q;
    st_d     = st_q;
    pend_d   = pend_q;
    lvl_d    = type_en ? type_lvl : lvl_q;
    if (soft_clr) begin
      server_d = '0;
      prio_d   = MASKED;
      saved_d  = MASKED;
      st_d     = '0;
      pend_d   = 1'b0;
    end else begin
      if (lvl_q) begin
        st_d[ST_ASSERTED] = line;
        if (accept) st_d[ST_SENT] = 1'b1;
      end else begin
        if (accept) pend_d = 1'b0;
        if (pend_q && prio_q == MASKED) begin
          pend_d = 1'b0;
          st_d[ST_MASKPEND] = 1'b1;
        end
        if (line) begin
          if (prio_q == MASKED) st_d[ST_MASKPEND] = 1'b1;
          else                  pend_d = 1'b1;
        end
        if (scan_hit && st_q[ST_REJECTED]) begin
          st_d[ST_REJECTED] = 1'b0;
          if (prio_q != MASKED) pend_d = 1'b1;
        end
      end
      if (wr_en) begin
        server_d = wr_server;
        prio_d   = wr_prio;
        saved_d  = wr_saved;
        if (!lvl_q && st_d[ST_MASKPEND] && wr_prio != MASKED) begin
          st_d[ST_MASKPEND] = 1'b0;
          pend_d = 1'b1;
        end
      end
      if (reject) begin
        st_d[ST_REJECTED] = 1'b1;
        st_d[ST_SENT]     = 1'b0;
      end
      if (eoi && lvl_q) st_d[ST_SENT] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      server_q <= '0;
      prio_q   <= MASKED;
      saved_q  <= MASKED;
      st_q     <= '0;
      pend_q   <= 1'b0;
      lvl_q    <= LVL_INIT;
    end else begin
      server_q <= server_d;
      prio_q   <= prio_d;
      saved_q  <= saved_d;
      st_q     <= st_d;
      pend_q   <= pend_d;
      lvl_q    <= lvl_d;
    end
  end

  assign req    = (prio_q != MASKED) &&
                  (lvl_q ? (st_q[ST_ASSERTED] && !st_q[ST_SENT]) : pend_q);
  assign server = server_q;
  assign prio   = prio_q;
  assign saved  = saved_q;
  assign status = st_q;
  assign lvl    = lvl_q;
endmodule

// File: rtl/irqsrc_pick.sv
module irqsrc_pick #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
  assign any = |req;
endmodule

// File: rtl/irqsrc_scan.sv
module irqsrc_scan #(
  parameter int NUM_SRC = 16,
  parameter int IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_clr,
  input  logic               start,
  input  logic               stall,
  output logic               busy,
  output logic [NUM_SRC-1:0] hit
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_SRC - 1);

  logic             busy_q, busy_d;
  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic             step;

  assign step = busy_q && !stall;

  always_comb begin
    busy_d = busy_q;
    ptr_d  = ptr_q;
    if (soft_clr) begin
      busy_d = 1'b0;
      ptr_d  = '0;
    end else if (!busy_q && start) begin
      busy_d = 1'b1;
      ptr_d  = '0;
    end else if (step) begin
      if (ptr_q == LAST) busy_d = 1'b0;
      else               ptr_d  = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ptr_q  <= '0;
    end else begin
      busy_q <= busy_d;
      ptr_q  <= ptr_d;
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_hit
    assign hit[i] = step && (ptr_q == IDX_W'(i));
  end

  assign busy = busy_q;
endmodule

// File: rtl/irq_source_ctl.sv
module irq_source_ctl
  import irqsrc_pkg::*;
#(
  parameter int                 NUM_SRC  = 16,
  parameter int                 NUM_SRV  = 4,
  parameter int                 SRV_W    = 4,
  parameter int                 PRIO_W   = 8,
  parameter int                 NUM_W    = 8,
  parameter int                 BASE     = 16,
  parameter logic [NUM_SRC-1:0] LVL_INIT = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_rst,
  input  logic [NUM_SRC-1:0] src_line,
  input  logic               cfg_valid,
  input  logic [2:0]         cfg_op,
  input  logic [NUM_W-1:0]   cfg_num,
  input  logic [SRV_W-1:0]   cfg_server,
  input  logic [PRIO_W-1:0]  cfg_prio,
  input  logic               cfg_lvl,
  output logic               cfg_ack,
  output logic               cfg_err,
  output logic [SRV_W-1:0]   rd_server,
  output logic [PRIO_W-1:0]  rd_prio,
  output logic [3:0]         rd_status,
  output logic               rd_lvl,
  input  logic               rej_valid,
  input  logic [NUM_W-1:0]   rej_num,
  input  logic               eoi_valid,
  input  logic [NUM_W-1:0]   eoi_num,
  input  logic               rsd_start,
  output logic               rsd_busy,
  output logic               dlv_valid,
  input  logic               dlv_ready,
  output logic [SRV_W-1:0]   dlv_server,
  output logic [NUM_W-1:0]   dlv_num,
  output logic [PRIO_W-1:0]  dlv_prio
);
  localparam int                IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam logic [PRIO_W-1:0] MASKED = '1;

  function automatic logic in_range(input logic [NUM_W-1:0] n);
    return (int'(n) >= BASE) && (int'(n) < BASE + NUM_SRC);
  endfunction

  function automatic logic [IDX_W-1:0] to_idx(input logic [NUM_W-1:0] n);
    return IDX_W'(n - NUM_W'(BASE));
  endfunction

  logic [SRV_W-1:0]  server_a [NUM_SRC];
  logic [PRIO_W-1:0] prio_a   [NUM_SRC];
  logic [PRIO_W-1:0] saved_a  [NUM_SRC];
  logic [ST_W-1:0]   status_a [NUM_SRC];
  logic [NUM_SRC-1:0] lvl_v, req_v, hit_v;

  logic [IDX_W-1:0]  cfg_idx, rej_idx, eoi_idx, pick_idx;
  logic              cfg_err_d, cfg_do, cfg_wr, rej_ok, eoi_ok, accept, stall;
  logic [SRV_W-1:0]  wr_server;
  logic [PRIO_W-1:0] wr_prio, wr_saved;

  assign cfg_idx = to_idx(cfg_num);
  assign rej_idx = to_idx(rej_num);
  assign eoi_idx = to_idx(eoi_num);
  assign rej_ok  = rej_valid && in_range(rej_num);
  assign eoi_ok  = eoi_valid && in_range(eoi_num);

  always_comb begin
    cfg_err_d = cfg_valid && (!in_range(cfg_num) || cfg_op > OP_TYPE ||
                (cfg_op == OP_SET && int'(cfg_server) >= NUM_SRV));
    cfg_do    = cfg_valid && !cfg_err_d;
    cfg_wr    = cfg_do && (cfg_op == OP_SET || cfg_op == OP_OFF || cfg_op == OP_ON);
    wr_server = server_a[cfg_idx];
    wr_prio   = prio_a[cfg_idx];
    wr_saved  = saved_a[cfg_idx];
    unique case (cfg_op)
      OP_SET: begin
        wr_server = cfg_server;
        wr_prio   = cfg_prio;
        wr_saved  = cfg_prio;
      end
      OP_OFF: begin
        wr_prio   = MASKED;
        wr_saved  = prio_a[cfg_idx];
      end
      OP_ON: begin
        wr_prio   = saved_a[cfg_idx];
      end
      default: ;
    endcase
  end

  assign stall  = dlv_valid && !dlv_ready;
  assign accept = dlv_valid && dlv_ready;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_slot
    irqsrc_slot #(
      .SRV_W(SRV_W), .PRIO_W(PRIO_W), .LVL_INIT(LVL_INIT[g])
    ) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .soft_clr  (soft_rst),
      .line      (src_line[g]),
      .wr_en     (cfg_wr && cfg_idx == IDX_W'(g)),
      .wr_server (wr_server),
      .wr_prio   (wr_prio),
      .wr_saved  (wr_saved),
      .type_en   (cfg_do && cfg_op == OP_TYPE && cfg_idx == IDX_W'(g)),
      .type_lvl  (cfg_lvl),
      .accept    (accept && pick_idx == IDX_W'(g)),
      .reject    (rej_ok && rej_idx == IDX_W'(g)),
      .eoi       (eoi_ok && eoi_idx == IDX_W'(g)),
      .scan_hit  (hit_v[g]),
      .req       (req_v[g]),
      .server    (server_a[g]),
      .prio      (prio_a[g]),
      .saved     (saved_a[g]),
      .status    (status_a[g]),
      .lvl       (lvl_v[g])
    );
  end

  irqsrc_pick #(.N(NUM_SRC), .IDX_W(IDX_W)) u_pick (
    .req (req_v),
    .any (dlv_valid),
    .idx (pick_idx)
  );

  irqsrc_scan #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_scan (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_clr (soft_rst),
    .start    (rsd_start),
    .stall    (stall),
    .busy     (rsd_busy),
    .hit      (hit_v)
  );

  assign dlv_server = server_a[pick_idx];
  assign dlv_prio   = prio_a[pick_idx];
  assign dlv_num    = NUM_W'(BASE) + NUM_W'(pick_idx);

  logic rd_en;
  assign rd_en = cfg_do && cfg_op == OP_GET;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_ack   <= 1'b0;
      cfg_err   <= 1'b0;
      rd_server <= '0;
      rd_prio   <= '0;
      rd_status <= '0;
      rd_lvl    <= 1'b0;
    end else begin
      cfg_ack <= cfg_valid;
      cfg_err <= cfg_err_d;
      if (rd_en) begin
        rd_server <= server_a[cfg_idx];
        rd_prio   <= prio_a[cfg_idx];
        rd_status <= status_a[cfg_idx];
        rd_lvl    <= lvl_v[cfg_idx];
      end
    end
  end
endmodule

// File: rtl/irqsrc_chk.sv
module irqsrc_chk
  import irqsrc_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int NUM_SRV = 4,
  parameter int SRV_W   = 4,
  parameter int PRIO_W  = 8,
  parameter int NUM_W   = 8,
  parameter int BASE    = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              soft_rst,
  input logic              cfg_valid,
  input logic [2:0]        cfg_op,
  input logic [SRV_W-1:0]  cfg_server,
  input logic              cfg_ack,
  input logic              cfg_err,
  input logic              rsd_busy,
  input logic              dlv_valid,
  input logic              dlv_ready,
  input logic [NUM_W-1:0]  dlv_num,
  input logic [PRIO_W-1:0] dlv_prio
);
  AST_DLV_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |-> dlv_prio != {PRIO_W{1'b1}}); // R3

  AST_DLV_NUM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |-> (int'(dlv_num) >= BASE && int'(dlv_num) < BASE + NUM_SRC)); // R1

  AST_SCAN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    rsd_busy && dlv_valid && !dlv_ready && !soft_rst |=> rsd_busy); // R12

  AST_CFG_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |=> cfg_ack); // R11

  AST_SRV_RANGE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && cfg_op == OP_SET && int'(cfg_server) >= NUM_SRV |=> cfg_err); // R11

  AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !dlv_valid && !rsd_busy); // R13
endmodule

bind irq_source_ctl irqsrc_chk #(
  .NUM_SRC(NUM_SRC), .NUM_SRV(NUM_SRV), .SRV_W(SRV_W),
  .PRIO_W(PRIO_W), .NUM_W(NUM_W), .BASE(BASE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .soft_rst   (soft_rst),
  .cfg_valid  (cfg_valid),
  .cfg_op     (cfg_op),
  .cfg_server (cfg_server),
  .cfg_ack    (cfg_ack),
  .cfg_err    (cfg_err),
  .rsd_busy   (rsd_busy),
  .dlv_valid  (dlv_valid),
  .dlv_ready  (dlv_ready),
  .dlv_num    (dlv_num),
  .dlv_prio   (dlv_prio)
);

// File: tb/tb_irq_source_ctl.sv
`timescale 1ns/1ps
module tb_irq_source_ctl;
  localparam int NUM_SRC = 16;
  localparam int NUM_W   = 8;
  localparam int SRV_W   = 4;
  localparam int PRIO_W  = 8;

  logic clk = 1'b0;
  logic rst_n, soft_rst;
  logic [NUM_SRC-1:0] src_line;
  logic cfg_valid, cfg_lvl;
  logic [2:0] cfg_op;
  logic [NUM_W-1:0] cfg_num, rej_num, eoi_num;
  logic [SRV_W-1:0] cfg_server;
  logic [PRIO_W-1:0] cfg_prio;
  logic cfg_ack, cfg_err, rd_lvl, rej_valid, eoi_valid, rsd_start, rsd_busy;
  logic [SRV_W-1:0] rd_server, dlv_server;
  logic [PRIO_W-1:0] rd_prio, dlv_prio;
  logic [3:0] rd_status;
  logic dlv_valid, dlv_ready;
  logic [NUM_W-1:0] dlv_num;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  irq_source_ctl dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .src_line(src_line),
    .cfg_valid(cfg_valid), .cfg_op(cfg_op), .cfg_num(cfg_num),
    .cfg_server(cfg_server), .cfg_prio(cfg_prio), .cfg_lvl(cfg_lvl),
    .cfg_ack(cfg_ack), .cfg_err(cfg_err), .rd_server(rd_server),
    .rd_prio(rd_prio), .rd_status(rd_status), .rd_lvl(rd_lvl),
    .rej_valid(rej_valid), .rej_num(rej_num), .eoi_valid(eoi_valid),
    .eoi_num(eoi_num), .rsd_start(rsd_start), .rsd_busy(rsd_busy),
    .dlv_valid(dlv_valid), .dlv_ready(dlv_ready), .dlv_server(dlv_server),
    .dlv_num(dlv_num), .dlv_prio(dlv_prio)
  );

  // op, num, server, prio, expected err, expected rd server, expected rd prio
  localparam int NV = 14;
  localparam logic [35:0] VEC [NV] = '{
    {3'd1, 8'd16, 4'd0, 8'h00, 1'b0, 4'd0, 8'hFF},
    {3'd0, 8'd17, 4'd2, 8'h05, 1'b0, 4'd0, 8'h00},
    {3'd1, 8'd17, 4'd0, 8'h00, 1'b0, 4'd2, 8'h05},
    {3'd2, 8'd17, 4'd0, 8'h00, 1'b0, 4'd0, 8'h00},
    {3'd1, 8'd17, 4'd0, 8'h00, 1'b0, 4'd2, 8'hFF},
    {3'd3, 8'd17, 4'd0, 8'h00, 1'b0, 4'd0, 8'h00},
    {3'd1, 8'd17, 4'd0, 8'h00, 1'b0, 4'd2, 8'h05},
    {3'd0, 8'd15, 4'd1, 8'h01, 1'b1, 4'd0, 8'h00},
    {3'd0, 8'd32, 4'd1, 8'h01, 1'b1, 4'd0, 8'h00},
    {3'd0, 8'd31, 4'd4, 8'h01, 1'b1, 4'd0, 8'h00},
    {3'd1, 8'd31, 4'd0, 8'h00, 1'b0, 4'd0, 8'hFF},
    {3'd0, 8'd31, 4'd3, 8'h10, 1'b0, 4'd0, 8'h00},
    {3'd1, 8'd31, 4'd0, 8'h00, 1'b0, 4'd3, 8'h10},
    {3'd7, 8'd20, 4'd0, 8'h00, 1'b1, 4'd0, 8'h00}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [2:0] op, input logic [7:0] num,
                     input logic [3:0] srv, input logic [7:0] pr, input logic lv);
    cfg_valid = 1'b1; cfg_op = op; cfg_num = num;
    cfg_server = srv; cfg_prio = pr; cfg_lvl = lv;
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic get_chk(input string tag, input logic [7:0] num, input logic [3:0] srv,
                         input logic [7:0] pr, input logic [3:0] st);
    cfg(3'd1, num, 4'd0, 8'd0, 1'b0);
    chk({tag, " server"}, 32'(rd_server), 32'(srv));
    chk({tag, " prio"}, 32'(rd_prio), 32'(pr));
    chk({tag, " status"}, 32'(rd_status), 32'(st));
  endtask

  task automatic pulse(input int i);
    src_line[i] = 1'b1;
    @(negedge clk);
    src_line[i] = 1'b0;
  endtask

  task automatic take();
    dlv_ready = 1'b1;
    @(negedge clk);
    dlv_ready = 1'b0;
  endtask

  task automatic reject(input logic [7:0] num);
    rej_valid = 1'b1; rej_num = num;
    @(negedge clk);
    rej_valid = 1'b0;
  endtask

  task automatic eoi(input logic [7:0] num);
    eoi_valid = 1'b1; eoi_num = num;
    @(negedge clk);
    eoi_valid = 1'b0;
  endtask

  task automatic wait_offer();
    for (int k = 0; k < 40 && !dlv_valid; k++) @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; soft_rst = 1'b0; src_line = '0;
    cfg_valid = 1'b0; cfg_op = '0; cfg_num = '0; cfg_server = '0;
    cfg_prio = '0; cfg_lvl = 1'b0;
    rej_valid = 1'b0; rej_num = '0; eoi_valid = 1'b0; eoi_num = '0;
    rsd_start = 1'b0; dlv_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state (R13)
    chk("R13 reset dlv_valid", 32'(dlv_valid), 0);
    chk("R13 reset rsd_busy", 32'(rsd_busy), 0);
    chk("R13 reset cfg_ack", 32'(cfg_ack), 0);

    // Configuration vector table (R1, R10, R11)
    for (int k = 0; k < NV; k++) begin
      logic [35:0] v;
      v = VEC[k];
      cfg(v[35:33], v[32:25], v[24:21], v[20:13], 1'b0);
      chk($sformatf("R11 ack vec%0d", k), 32'(cfg_ack), 1);
      chk($sformatf("R1/R11 err vec%0d", k), 32'(cfg_err), 32'(v[12]));
      if (v[35:33] == 3'd1 && !v[12]) begin
        chk($sformatf("R10 rd server vec%0d", k), 32'(rd_server), 32'(v[11:8]));
        chk($sformatf("R10 rd prio vec%0d", k), 32'(rd_prio), 32'(v[7:0]));
      end
    end
    chk("R3 no offer after table", 32'(dlv_valid), 0);

    // Message source, unmasked: offer and ordering (R3, R4)
    pulse(1);
    chk("R3 msi offer valid", 32'(dlv_valid), 1);
    chk("R4 msi num", 32'(dlv_num), 17);
    chk("R4 msi server", 32'(dlv_server), 2);
    chk("R4 msi prio", 32'(dlv_prio), 5);
    pulse(15);
    chk("R4 lowest index first", 32'(dlv_num), 17);
    take();
    chk("R4 next offer num", 32'(dlv_num), 31);
    chk("R4 next offer server", 32'(dlv_server), 3);
    take();
    chk("R4 drained", 32'(dlv_valid), 0);

    // Masked message source, then unmask by set (R3, R9, R2)
    pulse(2);
    chk("R3 masked no offer", 32'(dlv_valid), 0);
    get_chk("R2 masked-pending", 8'd18, 4'd0, 8'hFF, 4'h8);
    cfg(3'd0, 8'd18, 4'd1, 8'h07, 1'b0);
    chk("R9 release offer", 32'(dlv_valid), 1);
    chk("R9 release num", 32'(dlv_num), 18);
    chk("R9 release prio", 32'(dlv_prio), 7);
    take();
    get_chk("R9 flags cleared", 8'd18, 4'd1, 8'h07, 4'h0);

    // Level source (R5, R8, R13 type write)
    cfg(3'd4, 8'd20, 4'd0, 8'h00, 1'b1);
    cfg(3'd1, 8'd20, 4'd0, 8'h00, 1'b0);
    chk("R13 type write level", 32'(rd_lvl), 1);
    cfg(3'd0, 8'd20, 4'd1, 8'h03, 1'b0);
    src_line[4] = 1'b1;
    @(negedge clk);
    chk("R5 level offer", 32'(dlv_valid), 1);
    chk("R5 level num", 32'(dlv_num), 20);
    take();
    @(negedge clk);
    chk("R5 sent blocks re-offer", 32'(dlv_valid), 0);
    get_chk("R5 asserted+sent", 8'd20, 4'd1, 8'h03, 4'h3);
    eoi(8'd20);
    chk("R8 eoi re-offer", 32'(dlv_valid), 1);
    chk("R8 eoi re-offer num", 32'(dlv_num), 20);
    take();
    src_line[4] = 1'b0;
    @(negedge clk);
    eoi(8'd20);
    chk("R8 eoi line low", 32'(dlv_valid), 0);
    get_chk("R8 level idle", 8'd20, 4'd1, 8'h03, 4'h0);

    // Accept and reject of the same level source in one cycle (R6)
    src_line[4] = 1'b1;
    @(negedge clk);
    chk("R6 pre offer", 32'(dlv_num), 20);
    dlv_ready = 1'b1; rej_valid = 1'b1; rej_num = 8'd20;
    @(negedge clk);
    dlv_ready = 1'b0; rej_valid = 1'b0;
    chk("R6 same-cycle re-offer", 32'(dlv_valid), 1);
    get_chk("R6 same-cycle flags", 8'd20, 4'd1, 8'h03, 4'h5);
    take();
    chk("R6 lone accept clears offer", 32'(dlv_valid), 0);
    get_chk("R6 flags after accept", 8'd20, 4'd1, 8'h03, 4'h7);
    src_line[4] = 1'b0;
    @(negedge clk);
    eoi(8'd20);
    get_chk("R6 rejected kept", 8'd20, 4'd1, 8'h03, 4'h4);

    // Reject and resend of message sources (R6, R7, R8, R12)
    reject(8'd17);
    get_chk("R6 msi rejected", 8'd17, 4'd2, 8'h05, 4'h4);
    chk("R6 no offer before resend", 32'(dlv_valid), 0);
    eoi(8'd17);
    get_chk("R8 eoi no effect on msi", 8'd17, 4'd2, 8'h05, 4'h4);
    reject(8'd18);
    rsd_start = 1'b1;
    @(negedge clk);
    rsd_start = 1'b0;
    wait_offer();
    chk("R7 resend offer num", 32'(dlv_num), 17);
    repeat (5) @(negedge clk);
    chk("R12 scan stalls busy", 32'(rsd_busy), 1);
    chk("R12 offer held", 32'(dlv_num), 17);
    get_chk("R12 unvisited keeps flag", 8'd18, 4'd1, 8'h07, 4'h4);
    take();
    wait_offer();
    chk("R7 second resend num", 32'(dlv_num), 18);
    chk("R7 second resend prio", 32'(dlv_prio), 7);
    take();
    for (int k = 0; k < 40 && rsd_busy; k++) @(negedge clk);
    get_chk("R7 cleared 17", 8'd17, 4'd2, 8'h05, 4'h0);
    get_chk("R7 cleared 18", 8'd18, 4'd1, 8'h07, 4'h0);

    // Scan length: one source per cycle
    rsd_start = 1'b1;
    @(negedge clk);
    rsd_start = 1'b0;
    begin
      int cyc;
      cyc = 0;
      while (rsd_busy && cyc < 100) begin
        @(negedge clk);
        cyc++;
      end
      chk("R12 scan cycles", 32'(cyc), NUM_SRC);
    end

    // Disable/enable on a level source (R10, R9)
    cfg(3'd2, 8'd20, 4'd0, 8'h00, 1'b0);
    src_line[4] = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 disabled no offer", 32'(dlv_valid), 0);
    get_chk("R10 disabled prio", 8'd20, 4'd1, 8'hFF, 4'h5);
    cfg(3'd3, 8'd20, 4'd0, 8'h00, 1'b0);
    chk("R9 enable level offer", 32'(dlv_valid), 1);
    chk("R10 restored prio", 32'(dlv_prio), 3);
    take();
    src_line[4] = 1'b0;
    @(negedge clk);
    eoi(8'd20);

    // Queued message request masked before acceptance (R3)
    pulse(1);
    chk("R3 queued offer", 32'(dlv_num), 17);
    cfg(3'd2, 8'd17, 4'd0, 8'h00, 1'b0);
    chk("R3 masked drops offer", 32'(dlv_valid), 0);
    @(negedge clk);
    get_chk("R3 queued to masked-pending", 8'd17, 4'd2, 8'hFF, 4'h8);
    cfg(3'd3, 8'd17, 4'd0, 8'h00, 1'b0);
    chk("R9 enable releases", 32'(dlv_num), 17);
    chk("R9 enable prio", 32'(dlv_prio), 5);
    take();

    // Soft reset keeps type (R13)
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    chk("R13 soft no offer", 32'(dlv_valid), 0);
    get_chk("R13 soft level src", 8'd20, 4'd0, 8'hFF, 4'h0);
    chk("R13 type kept", 32'(rd_lvl), 1);
    get_chk("R13 soft msi src", 8'd17, 4'd0, 8'hFF, 4'h0);
    chk("R13 msi type kept", 32'(rd_lvl), 0);
    cfg(3'd3, 8'd17, 4'd0, 8'h00, 1'b0);
    get_chk("R13 saved cleared", 8'd17, 4'd0, 8'hFF, 4'h0);

    finished = 1;
    summary();
    $finish;
  end
endmodule